// File: doc/BRIEF.md
# Single-Wire Bus Device Bit Responder

This block is the device end of a single-wire, open-drain bus, where a pull-up holds the line high and any party may pull it low. All timing is taken from the falling edges the bus master makes. The block measures how long the line stays low, counting in microseconds from a tick it derives from the system clock. A low period long enough to be a bus reset makes the block answer with a presence pulse after a short delay. Any shorter master low period is a bit slot.

In receive mode each slot is read as a write-1 or a write-0 from the line level sampled at a fixed point inside the slot. The bits collect least significant first, and the block strobes a received byte to the local logic after eight slots. When the local logic loads a transmit byte, the next eight slots are served as read slots instead. A 0 bit is sent by holding the line low until well into the slot. A 1 bit is sent by leaving the line alone. The block then falls back to receive mode.

The block only drives the line low, through `lineDrvLow`. The resolved bus level comes back on `lineIn` and passes through a two-flop synchronizer before any use.

Top module: `owSlaveBit`

## Requirements
- R1: After `rstN` is released, `lineDrvLow`, `rxStrobe` and `rxData` are all 0.
- R2: A bus low period of RESET_US (480) microseconds or longer is taken as a bus reset in every state. The block stops any drive and waits for the line to rise.
- R3: After the line rises at the end of a bus reset, the block waits PRES_DLY_US (30) microseconds and then holds `lineDrvLow` high for PRES_LEN_US (120) microseconds. Apart from this presence pulse and read-0 slots, it never drives.
- R4: In receive mode, the line is sampled SAMPLE_US (30) microseconds after the master's falling edge. High gives bit 1 and low gives bit 0. The block does not drive during such a slot.
- R5: Received bits fill `rxData` least significant bit first. `rxStrobe` pulses for exactly one clock after the eighth receive slot, with the new byte on `rxData`.
- R6: A `txLoad` pulse captures `txData` and switches the block to transmit mode for the next eight slots, least significant bit first. A 0 bit holds `lineDrvLow` high from the falling edge until HOLD_US (45) microseconds. A 1 bit never drives. Transmit slots produce no `rxStrobe`, and after eight of them the block is back in receive mode.
- R7: A low period shorter than RESET_US is a data slot, not a bus reset. It brings no presence pulse.
- R8: A falling line level caused by the block's own drive does not start a slot. The presence pulse and read-0 holds are never counted as bits.
- R9: A bus reset clears the bit count and cancels a pending transmit byte. A partly received byte is discarded, and the slots after the reset are receive slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 1 | Resolved level of the bus line |
| lineDrvLow | output | 1 | 1 pulls the bus line low |
| txLoad | input | 1 | One-cycle pulse that loads a transmit byte |
| txData | input | BYTE_W | Byte to send in read slots |
| rxData | output | BYTE_W | Last received byte |
| rxStrobe | output | 1 | One-cycle pulse when `rxData` is new |

## Verification
The bench goes after a bus reset that lands partway through a byte in each direction. A design that kept its bit count would strobe early or shift the next byte, and one that kept the pending transmit byte would go on pulling zeros onto the bus. A 400 µs low period must decode as a single 0 bit with no presence pulse, which catches a reset threshold set too low. Every byte that follows a presence pulse, or a read slot carrying a 0, is checked bit for bit. A design that took its own drive for a master edge would gain extra bits and misalign those bytes. The read-0 hold is probed on both sides of its 45 µs end, which catches a release that is too early or too late.

// File: rtl/owSlavePkg.sv
package owSlavePkg;

  // Strobes from control to datapath, all one clock wide.
  typedef struct packed {
    logic clrAll;     // bus reset seen: drop bit count and pending tx
    logic sampleBit;  // shift the current line level into the rx byte
    logic txAdvance;  // one transmit bit has been served
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RSTLOW,
    ST_PWAIT,
    ST_PDRV
  } ctlState_t;

endpackage

// File: rtl/owSlaveDp.sv
module owSlaveDp
  import owSlavePkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int RESET_US   = 480,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              drvLow,
  input  logic              txLoad,
  input  logic [BYTE_W-1:0] txData,
  input  ctlStrobe_t        ctl,
  output logic              usTick,
  output logic              fallEdge,
  output logic              riseEdge,
  output logic              resetHit,
  output logic              txValid,
  output logic              txBit,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxStrobe
);

  localparam int DW  = $clog2(CLK_PER_US + 1);
  localparam int LW  = $clog2(RESET_US + 1);
  localparam int BCW = $clog2(BYTE_W);

  logic [1:0]        syncQ;
  logic              prevLvl;
  logic              lineLvl;
  logic [DW-1:0]     divCnt;
  logic [LW-1:0]     lowUs;
  logic [BCW-1:0]    bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic              lastBit;

  // Two-flop synchronizer; idle bus is high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      prevLvl <= 1'b1;
    end else begin
      syncQ   <= {syncQ[0], lineIn};
      prevLvl <= syncQ[1];
    end
  end

  assign lineLvl  = syncQ[1];
  assign fallEdge = prevLvl & ~lineLvl & ~drvLow;
  assign riseEdge = ~prevLvl & lineLvl;

  // Microsecond tick prescaler.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (usTick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign usTick = (divCnt == DW'(CLK_PER_US - 1));

  // Low-duration meter, independent of the slot state machine.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowUs <= '0;
    else if (lineLvl) lowUs <= '0;
    else if (usTick && lowUs != LW'(RESET_US)) lowUs <= lowUs + 1'b1;
  end

  assign resetHit = usTick & ~lineLvl & (lowUs == LW'(RESET_US - 1));

  // Shared bit counter and shift registers.
  assign lastBit = (bitCnt == BCW'(BYTE_W - 1));
  assign txBit   = txShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      txValid  <= 1'b0;
      rxData   <= '0;
      rxStrobe <= 1'b0;
    end else begin
      rxStrobe <= 1'b0;
      if (ctl.clrAll) begin
        bitCnt  <= '0;
        txValid <= 1'b0;
        rxShift <= '0;
      end else if (txLoad) begin
        txShift <= txData;
        txValid <= 1'b1;
        bitCnt  <= '0;
      end else if (ctl.sampleBit) begin
        rxShift <= {lineLvl, rxShift[BYTE_W-1:1]};
        if (lastBit) begin
          rxData   <= {lineLvl, rxShift[BYTE_W-1:1]};
          rxStrobe <= 1'b1;
          bitCnt   <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (ctl.txAdvance) begin
        txShift <= txShift >> 1;
        if (lastBit) begin
          txValid <= 1'b0;
          bitCnt  <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R5: the byte strobe lasts a single clock
  assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> !rxStrobe);

  // R6: a load outside a bus reset arms transmit mode
  assert_load_arms_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && !ctl.clrAll) |=> txValid);

  // R9: a bus reset leaves no count and no pending byte
  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrAll |=> (bitCnt == '0 && !txValid));

  // R6: a slot is either received or transmitted, never both
  assert_one_direction_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.sampleBit && ctl.txAdvance));

endmodule

// File: rtl/owSlaveCtl.sv
module owSlaveCtl
  import owSlavePkg::*;
#(
  parameter int SAMPLE_US   = 30,
  parameter int HOLD_US     = 45,
  parameter int PRES_DLY_US = 30,
  parameter int PRES_LEN_US = 120
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       fallEdge,
  input  logic       riseEdge,
  input  logic       resetHit,
  input  logic       txValid,
  input  logic       txBit,
  output ctlStrobe_t ctl,
  output logic       drvLow
);

  localparam int M1   = (PRES_LEN_US > PRES_DLY_US) ? PRES_LEN_US : PRES_DLY_US;
  localparam int M2   = (HOLD_US > SAMPLE_US) ? HOLD_US : SAMPLE_US;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 1);

  ctlState_t     state;
  logic [TW-1:0] timer;
  logic          slotRead;
  logic          atSample;
  logic          atHold;

  assign atSample = usTick && (timer == TW'(SAMPLE_US - 1));
  assign atHold   = usTick && (timer == TW'(HOLD_US - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      slotRead <= 1'b0;
      drvLow   <= 1'b0;
    end else if (resetHit) begin
      state  <= ST_RSTLOW;
      timer  <= '0;
      drvLow <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fallEdge) begin
            state    <= ST_SLOT;
            timer    <= '0;
            slotRead <= txValid;
            drvLow   <= txValid & ~txBit;
          end
        end
        ST_SLOT: begin
          if (usTick) timer <= timer + 1'b1;
          if (atHold) begin
            drvLow <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        ST_RSTLOW: begin
          if (riseEdge) begin
            state <= ST_PWAIT;
            timer <= '0;
          end
        end
        ST_PWAIT: begin
          if (usTick) timer <= timer + 1'b1;
          if (usTick && timer == TW'(PRES_DLY_US - 1)) begin
            state  <= ST_PDRV;
            timer  <= '0;
            drvLow <= 1'b1;
          end
        end
        ST_PDRV: begin
          if (usTick) timer <= timer + 1'b1;
          if (usTick && timer == TW'(PRES_LEN_US - 1)) begin
            state  <= ST_IDLE;
            drvLow <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clrAll    = resetHit;
    ctl.sampleBit = (state == ST_SLOT) && !slotRead && atSample && !resetHit;
    ctl.txAdvance = (state == ST_SLOT) && slotRead && atHold && !resetHit;
  end

  // R3: the line is driven only for presence or inside a slot
  assert_drive_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    drvLow |-> (state == ST_PDRV || state == ST_SLOT));

  // R2: a long low always lands in the reset-wait state
  assert_reset_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    resetHit |=> (state == ST_RSTLOW && !drvLow));

  // R4: receive slots never pull the line
  assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLOT && !slotRead) |-> !drvLow);

  // R6: a slot never outlasts the hold window
  assert_hold_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLOT) |-> (timer < TW'(HOLD_US)));

endmodule

// File: rtl/owSlaveBit.sv
module owSlaveBit
  import owSlavePkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int RESET_US    = 480,
  parameter int PRES_DLY_US = 30,
  parameter int PRES_LEN_US = 120,
  parameter int SAMPLE_US   = 30,
  parameter int HOLD_US     = 45,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  output logic              lineDrvLow,
  input  logic              txLoad,
  input  logic [BYTE_W-1:0] txData,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxStrobe
);

  ctlStrobe_t ctlQ;
  logic usTick, fallEdge, riseEdge, resetHit, txValid, txBit;

  owSlaveDp #(
    .CLK_PER_US(CLK_PER_US),
    .RESET_US  (RESET_US),
    .BYTE_W    (BYTE_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (lineIn),
    .drvLow  (lineDrvLow),
    .txLoad  (txLoad),
    .txData  (txData),
    .ctl     (ctlQ),
    .usTick  (usTick),
    .fallEdge(fallEdge),
    .riseEdge(riseEdge),
    .resetHit(resetHit),
    .txValid (txValid),
    .txBit   (txBit),
    .rxData  (rxData),
    .rxStrobe(rxStrobe)
  );

  owSlaveCtl #(
    .SAMPLE_US  (SAMPLE_US),
    .HOLD_US    (HOLD_US),
    .PRES_DLY_US(PRES_DLY_US),
    .PRES_LEN_US(PRES_LEN_US)
  ) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .usTick  (usTick),
    .fallEdge(fallEdge),
    .riseEdge(riseEdge),
    .resetHit(resetHit),
    .txValid (txValid),
    .txBit   (txBit),
    .ctl     (ctlQ),
    .drvLow  (lineDrvLow)
  );

endmodule

// File: tb/sim_owSlaveBit.sv
module sim_owSlaveBit;

  localparam int US = 4;  // clocks per microsecond in this bench

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterLow = 1'b0;
  logic       txLoad = 1'b0;
  logic [7:0] txData = '0;
  logic       lineIn;
  logic       lineDrvLow;
  logic [7:0] rxData;
  logic       rxStrobe;

  int   total = 0;
  int   bad = 0;
  int   strobeCnt = 0;
  logic [7:0] lastRx = '0;
  bit   finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign lineIn = ~(masterLow | lineDrvLow);

  owSlaveBit #(.CLK_PER_US(US)) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .lineDrvLow(lineDrvLow),
    .txLoad    (txLoad),
    .txData    (txData),
    .rxData    (rxData),
    .rxStrobe  (rxStrobe)
  );

  always @(negedge clk) begin
    if (rxStrobe) begin
      strobeCnt = strobeCnt + 1;
      lastRx    = rxData;
    end
  end

  // bit 8 set = transmit vector, bits 7:0 = byte
  localparam logic [8:0] VECS [6] = '{9'h0A5, 9'h001, 9'h15A, 9'h180, 9'h0FF, 9'h100};

  task automatic waitUs(input int n);
    repeat (n * US) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busReset();
    masterLow = 1'b1;
    waitUs(500);
    masterLow = 1'b0;
    waitUs(20);  chk("R3 no drive before presence", lineDrvLow, 0);
    waitUs(20);  chk("R3 presence low at 40us", lineDrvLow, 1);
    waitUs(100); chk("R3 presence low at 140us", lineDrvLow, 1);
    waitUs(25);  chk("R3 presence released", lineDrvLow, 0);
    waitUs(35);
  endtask

  task automatic writeBit(input logic b);
    masterLow = 1'b1;
    if (b) begin waitUs(6); masterLow = 1'b0; waitUs(64); end
    else begin waitUs(65); masterLow = 1'b0; waitUs(5); end
  endtask

  task automatic writeByte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) writeBit(d[i]);
    waitUs(2);
  endtask

  task automatic readBit(output logic b);
    masterLow = 1'b1;
    waitUs(2);
    masterLow = 1'b0;
    waitUs(10);
    b = lineIn;
    waitUs(58);
  endtask

  task automatic readByte(output logic [7:0] d);
    logic b;
    for (int i = 0; i < 8; i++) begin readBit(b); d[i] = b; end
  endtask

  task automatic loadTx(input logic [7:0] d);
    txData = d; txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic       b;
    int         cnt0;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 drive idle", lineDrvLow, 0);
    chk("R1 strobe idle", rxStrobe, 0);
    chk("R1 rxData zero", rxData, 0);

    busReset();  // R2, R3

    // Vector table: bytes right after presence also cover R8
    for (int v = 0; v < 6; v++) begin
      cnt0 = strobeCnt;
      if (VECS[v][8]) begin
        loadTx(VECS[v][7:0]);
        readByte(got);
        chk("R6 read byte", got, VECS[v][7:0]);
        chk("R6 no rx strobe on read", strobeCnt, cnt0);
      end else begin
        writeByte(VECS[v][7:0]);
        chk("R5 one strobe per byte", strobeCnt, cnt0 + 1);
        chk("R4 R5 received byte", lastRx, VECS[v][7:0]);
      end
    end

    // R9: reset aborts a partly received byte
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1);
    cnt0 = strobeCnt;
    busReset();
    writeByte(8'h3C);
    chk("R9 rx restarts after reset", lastRx, 8'h3C);
    chk("R9 single strobe after reset", strobeCnt, cnt0 + 1);

    // R7: a 400us low is a 0 bit, not a reset
    masterLow = 1'b1;
    waitUs(400);
    masterLow = 1'b0;
    waitUs(40);  chk("R7 no presence at 40us", lineDrvLow, 0);
    waitUs(100); chk("R7 no presence at 140us", lineDrvLow, 0);
    for (int i = 0; i < 7; i++) writeBit(1'b1);
    waitUs(2);
    chk("R7 long low decoded as bit 0", lastRx, 8'hFE);

    // R6: read-0 hold window, then remaining ones
    loadTx(8'hFE);
    masterLow = 1'b1;
    waitUs(2);
    masterLow = 1'b0;
    waitUs(38); chk("R6 zero held at 40us", lineDrvLow, 1);
    waitUs(10); chk("R6 zero released at 50us", lineDrvLow, 0);
    waitUs(20);
    got = '0;
    for (int i = 1; i < 8; i++) begin readBit(b); got[i] = b; end
    chk("R6 R8 remaining tx bits", got, 8'hFE);

    // R9: reset cancels a pending transmit byte
    loadTx(8'h00);
    for (int i = 0; i < 3; i++) begin readBit(b); chk("R6 tx zero bit", b, 0); end
    busReset();
    cnt0 = strobeCnt;
    readByte(got);
    chk("R9 tx cancelled, line released", got, 8'hFF);
    chk("R9 slots received after reset", lastRx, 8'hFF);
    chk("R9 strobe count", strobeCnt, cnt0 + 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule